// File: doc/BRIEF.md
# Dual-Successor Accumulator Processor Core

This block is a small Harvard-style processor core with an 8-bit datapath. Instructions are 32 bits wide and live in an internal program store of 256 words, addressed by an 8-bit state register. Data accesses use a 16-bit address whose high byte is a page register and whose low byte comes either from the instruction or from an indirection register. Data addresses whose top four bits are zero hit an internal byte-wide RAM indexed by the low twelve bits. Every other address is served by an external device through the read-data input. Every access, to RAM or to a device, appears on the bus address, strobe and write-data outputs.

There is no incrementing program counter. Each instruction carries two candidate successor addresses, and the flag produced by that instruction chooses one of them. An instruction runs in three phases: fetch, operand read, and writeback, in which the result is written and the successor is loaded. A phase advances on every clock while running in automatic mode, or once per step pulse in manual mode. Load ports let a host write any register or any program word. The arithmetic unit is a separate instantiated block.

Top module: `dnc_core`

## Requirements
- R1: The data address is {page, low}. The low byte is instruction bits [23:16] when instruction bit 24 is 0, and the indirection register when bit 24 is 1.
- R2: Instruction bits [30:27] are the opcode and bits [26:25] pick the destination: 00 accumulator, 01 data memory/device at the formed address, 10 indirection register, 11 page register. Destinations that are not selected keep their values.
- R3: At writeback the state register loads instruction bits [7:0] when the new flag is 0 and bits [15:8] when it is 1.
- R4: Opcodes 0000 pass acc, 0001 pass mem, 0010 acc^mem, 0011 zero, 0100 ~acc, 0101 ~mem, 0110 acc&mem and 0111 acc|mem each set the flag when the result is zero. Opcode 1111 passes acc and clears the flag.
- R5: Opcodes 1000/1001 rotate acc left/right and 1010/1011 rotate mem left/right by one bit. The flag is the MSB of the result.
- R6: Opcodes 1100 (acc+mem), 1101 (acc+1) and 1110 (mem+1) keep the low 8 bits and set the flag to the carry out.
- R7: Phases go fetch, read, writeback and back to fetch, one per advance. busRd is high throughout the read phase.
- R8: In manual mode a phase advances only on a cycle where step is high. When run is low nothing advances and no register changes.
- R9: busWr pulses for exactly the advancing writeback cycle of an instruction whose destination is 01, carrying the result on busWrData. It never pulses otherwise.
- R10: Addresses with bits [15:12] equal to 0 read and write the internal RAM. Any other address takes its operand from busRdData.
- R11: Reset clears the accumulator, page register and flag, and returns the sequencer to fetch. The state and indirection registers keep their values.
- R12: When regWe is high, regSel 00/01/10/11 loads regData into the accumulator, state, indirection or page register. A load takes priority over writeback. progWe writes progData to program word progAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execution enable; low halts |
| manual | input | 1 | 1 = single-phase stepping |
| step | input | 1 | Advance one phase in manual mode |
| regWe | input | 1 | Register load strobe |
| regSel | input | 2 | Register select for loads |
| regData | input | 8 | Register load value |
| progWe | input | 1 | Program word write strobe |
| progAddr | input | 8 | Program word address |
| progData | input | 32 | Program word value |
| busAddr | output | 16 | Formed data address |
| busWrData | output | 8 | Write data (ALU result) |
| busRdData | input | 8 | Device read data |
| busRd | output | 1 | Read phase strobe |
| busWr | output | 1 | Write pulse |
| accOut | output | 8 | Accumulator value |
| pageOut | output | 8 | Page register value |
| indOut | output | 8 | Indirection register value |
| stateOut | output | 8 | State (program address) register |
| flagOut | output | 1 | Result flag |

## Verification
The hardest cases to reach are a halt, or a reset, that lands in the middle of an instruction. They are visible only as the absence of change at the ports. The bench stops the run input after a single fetch, holds it low for several cycles and checks that the state and accumulator are untouched. It then advances one more phase and resets, and checks that the same instruction runs again from fetch. Manual stepping is driven one pulse at a time, with the bus strobes sampled between pulses. The write pulse is shown to coincide with the stepping cycle, not with the whole writeback phase.

// File: rtl/dnc_pkg.sv
package dnc_pkg;
  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_READ  = 2'd1,
    PH_WB    = 2'd2
  } phase_e;

  typedef struct packed {
    logic fetchEn;
    logic readEn;
    logic wbEn;
    logic inRead;
    logic inWb;
  } seqCtl_t;

  typedef enum logic [3:0] {
    OP_ACC, OP_MEM, OP_XOR, OP_CLR, OP_NOA, OP_NOM, OP_AND, OP_OR,
    OP_RLA, OP_RRA, OP_RLM, OP_RRM, OP_ADD, OP_INA, OP_INM, OP_NOP
  } aluOp_e;

  typedef enum logic [1:0] {
    DST_ACC  = 2'b00,
    DST_MEM  = 2'b01,
    DST_IND  = 2'b10,
    DST_PAGE = 2'b11
  } dest_e;

  localparam logic [1:0] SEL_ACC   = 2'b00;
  localparam logic [1:0] SEL_STATE = 2'b01;
  localparam logic [1:0] SEL_IND   = 2'b10;
  localparam logic [1:0] SEL_PAGE  = 2'b11;
endpackage

// File: rtl/dnc_alu.sv
module dnc_alu
  import dnc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] memIn,
  input  aluOp_e       op,
  output logic [W-1:0] res,
  output logic         flag
);
  logic [W:0] sum;

  always_comb begin
    sum = '0;
    res = accIn;
    case (op)
      OP_ACC: res = accIn;
      OP_MEM: res = memIn;
      OP_XOR: res = accIn ^ memIn;
      OP_CLR: res = '0;
      OP_NOA: res = ~accIn;
      OP_NOM: res = ~memIn;
      OP_AND: res = accIn & memIn;
      OP_OR:  res = accIn | memIn;
      OP_RLA: res = {accIn[W-2:0], accIn[W-1]};
      OP_RRA: res = {accIn[0], accIn[W-1:1]};
      OP_RLM: res = {memIn[W-2:0], memIn[W-1]};
      OP_RRM: res = {memIn[0], memIn[W-1:1]};
      OP_ADD: begin sum = {1'b0, accIn} + {1'b0, memIn}; res = sum[W-1:0]; end
      OP_INA: begin sum = {1'b0, accIn} + (W+1)'(1);     res = sum[W-1:0]; end
      OP_INM: begin sum = {1'b0, memIn} + (W+1)'(1);     res = sum[W-1:0]; end
      default: res = accIn;
    endcase

    case (op)
      OP_RLA, OP_RRA, OP_RLM, OP_RRM: flag = res[W-1];
      OP_ADD, OP_INA, OP_INM:         flag = sum[W];
      OP_NOP:                         flag = 1'b0;
      default:                        flag = (res == '0);
    endcase
  end
endmodule

// File: rtl/dnc_ctrl.sv
module dnc_ctrl
  import dnc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    run,
  input  logic    manual,
  input  logic    step,
  output phase_e  phase,
  output seqCtl_t ctl
);
  logic advance;

  assign advance = run & (manual ? step : 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_FETCH;
    end else if (advance) begin
      case (phase)
        PH_FETCH: phase <= PH_READ;
        PH_READ:  phase <= PH_WB;
        default:  phase <= PH_FETCH;
      endcase
    end
  end

  always_comb begin
    ctl.fetchEn = advance && (phase == PH_FETCH);
    ctl.readEn  = advance && (phase == PH_READ);
    ctl.wbEn    = advance && (phase == PH_WB);
    ctl.inRead  = (phase == PH_READ);
    ctl.inWb    = (phase == PH_WB);
  end

  // R7
  phase_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && phase == PH_FETCH) |=> (phase == PH_READ));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!advance) |=> $stable(phase));
endmodule

// File: rtl/dnc_datapath.sv
module dnc_datapath
  import dnc_pkg::*;
#(
  parameter int PW     = 8,
  parameter int DW     = 8,
  parameter int RAM_AW = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqCtl_t         ctl,
  input  logic            regWe,
  input  logic [1:0]      regSel,
  input  logic [DW-1:0]   regData,
  input  logic            progWe,
  input  logic [PW-1:0]   progAddr,
  input  logic [4*DW-1:0] progData,
  output logic [2*DW-1:0] busAddr,
  output logic [DW-1:0]   busWrData,
  input  logic [DW-1:0]   busRdData,
  output logic            busRd,
  output logic            busWr,
  output logic [DW-1:0]   accOut,
  output logic [DW-1:0]   pageOut,
  output logic [DW-1:0]   indOut,
  output logic [PW-1:0]   stateOut,
  output logic            flagOut
);
  localparam int IW        = 4 * DW;
  localparam int AW        = 2 * DW;
  localparam int PDEPTH    = 1 << PW;
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [IW-1:0] progMem [PDEPTH];
  logic [DW-1:0] ram [RAM_DEPTH];
  logic [IW-1:0] instr;
  logic [DW-1:0] accR, pageR, indR, operand;
  logic [PW-1:0] stateR;
  logic          flagR;

  aluOp_e        opcode;
  dest_e         dest;
  logic          useInd;
  logic [DW-1:0] lowAddr;
  logic [PW-1:0] nextClr, nextSet;
  logic          isRam;
  logic [DW-1:0] aluRes;
  logic          aluFlag;

  assign opcode  = aluOp_e'(instr[IW-2 -: 4]);
  assign dest    = dest_e'(instr[IW-6 -: 2]);
  assign useInd  = instr[IW-8];
  assign lowAddr = useInd ? indR : instr[IW-9 -: DW];
  assign nextClr = instr[PW-1:0];
  assign nextSet = instr[DW +: PW];
  assign busAddr = {pageR, lowAddr};
  assign isRam   = (busAddr[AW-1:RAM_AW] == '0);

  assign busRd     = ctl.inRead;
  assign busWr     = ctl.wbEn && (dest == DST_MEM);
  assign busWrData = aluRes;

  dnc_alu #(.W(DW)) alu_i (
    .accIn (accR),
    .memIn (operand),
    .op    (opcode),
    .res   (aluRes),
    .flag  (aluFlag)
  );

  always_ff @(posedge clk) begin
    if (progWe) progMem[progAddr] <= progData;
  end

  always_ff @(posedge clk) begin
    if (busWr && isRam) ram[busAddr[RAM_AW-1:0]] <= aluRes;
  end

  always_ff @(posedge clk) begin
    if (ctl.fetchEn) instr <= progMem[stateR];
    if (ctl.readEn)  operand <= isRam ? ram[busAddr[RAM_AW-1:0]] : busRdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR  <= '0;
      pageR <= '0;
      flagR <= 1'b0;
    end else begin
      if (regWe && regSel == SEL_ACC)          accR <= regData;
      else if (ctl.wbEn && dest == DST_ACC)    accR <= aluRes;
      if (regWe && regSel == SEL_PAGE)         pageR <= regData;
      else if (ctl.wbEn && dest == DST_PAGE)   pageR <= aluRes;
      if (ctl.wbEn)                            flagR <= aluFlag;
    end
  end

  always_ff @(posedge clk) begin
    if (regWe && regSel == SEL_IND)            indR <= regData;
    else if (ctl.wbEn && dest == DST_IND)      indR <= aluRes;
    if (regWe && regSel == SEL_STATE)          stateR <= regData[PW-1:0];
    else if (ctl.wbEn)                         stateR <= aluFlag ? nextSet : nextClr;
  end

  assign accOut   = accR;
  assign pageOut  = pageR;
  assign indOut   = indR;
  assign stateOut = stateR;
  assign flagOut  = flagR;

  // R3
  next_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wbEn && !regWe) |=> (stateR == (flagR ? $past(nextSet) : $past(nextClr))));

  // R12
  acc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regSel == SEL_ACC) |=> (accR == $past(regData)));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  // R10
  dev_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.readEn && !isRam) |=> (operand == $past(busRdData)));
endmodule

// File: rtl/dnc_core.sv
module dnc_core
  import dnc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        run,
  input  logic        manual,
  input  logic        step,
  input  logic        regWe,
  input  logic [1:0]  regSel,
  input  logic [7:0]  regData,
  input  logic        progWe,
  input  logic [7:0]  progAddr,
  input  logic [31:0] progData,
  output logic [15:0] busAddr,
  output logic [7:0]  busWrData,
  input  logic [7:0]  busRdData,
  output logic        busRd,
  output logic        busWr,
  output logic [7:0]  accOut,
  output logic [7:0]  pageOut,
  output logic [7:0]  indOut,
  output logic [7:0]  stateOut,
  output logic        flagOut
);
  phase_e  phase;
  seqCtl_t ctl;

  dnc_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .run    (run),
    .manual (manual),
    .step   (step),
    .phase  (phase),
    .ctl    (ctl)
  );

  dnc_datapath #(.PW(8), .DW(8), .RAM_AW(12)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .regWe     (regWe),
    .regSel    (regSel),
    .regData   (regData),
    .progWe    (progWe),
    .progAddr  (progAddr),
    .progData  (progData),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .busRd     (busRd),
    .busWr     (busWr),
    .accOut    (accOut),
    .pageOut   (pageOut),
    .indOut    (indOut),
    .stateOut  (stateOut),
    .flagOut   (flagOut)
  );

  // R11
  fetch_after_reset_chk: assert property (@(posedge clk)
    (!rstN) |=> (phase == PH_FETCH || rstN));
endmodule

// File: tb/dnc_core_tb_top.sv
module dnc_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN, run, manual, step, regWe, progWe;
  logic [1:0]  regSel;
  logic [7:0]  regData, progAddr;
  logic [31:0] progData;
  logic [15:0] busAddr;
  logic [7:0]  busWrData, busRdData;
  logic        busRd, busWr;
  logic [7:0]  accOut, pageOut, indOut, stateOut;
  logic        flagOut;

  int compared = 0;
  int mismatched = 0;
  int wrCount = 0;
  logic [15:0] lastWrAddr, lastRdAddr;
  logic [7:0]  lastWrData;

  always #5 clk = ~clk;

  // device model: read data derived from the address
  assign busRdData = busAddr[7:0] ^ 8'h5A;

  always @(negedge clk) begin
    if (busWr) begin
      wrCount++;
      lastWrAddr = busAddr;
      lastWrData = busWrData;
    end
    if (busRd) lastRdAddr = busAddr;
  end

  dnc_core dut_i (
    .clk(clk), .rstN(rstN), .run(run), .manual(manual), .step(step),
    .regWe(regWe), .regSel(regSel), .regData(regData),
    .progWe(progWe), .progAddr(progAddr), .progData(progData),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busRd(busRd), .busWr(busWr), .accOut(accOut), .pageOut(pageOut),
    .indOut(indOut), .stateOut(stateOut), .flagOut(flagOut)
  );

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [1:0] dst,
                                     input logic ib, input logic [7:0] lo,
                                     input logic [7:0] nx0, input logic [7:0] nx1);
    return {1'b0, op, dst, ib, lo, nx1, nx0};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic setReg(input logic [1:0] sel, input logic [7:0] val);
    @(posedge clk); #1 regWe = 1'b1; regSel = sel; regData = val;
    @(posedge clk); #1 regWe = 1'b0;
  endtask

  task automatic putProg(input logic [7:0] a, input logic [31:0] w);
    @(posedge clk); #1 progWe = 1'b1; progAddr = a; progData = w;
    @(posedge clk); #1 progWe = 1'b0;
  endtask

  task automatic doReset();
    @(posedge clk); #1 rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic runInstr();
    @(posedge clk); #1 run = 1'b1; manual = 1'b0;
    repeat (3) @(posedge clk);
    #1 run = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseStep();
    @(posedge clk); #1 step = 1'b1;
    @(posedge clk); #1 step = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    setReg(2'b01, 8'h20);
    setReg(2'b00, 8'h77);
    @(negedge clk); chk("R12 acc load", accOut, 8'h77);
    setReg(2'b11, 8'h31);
    setReg(2'b10, 8'h45);
    @(negedge clk); chk("R12 page load", pageOut, 8'h31);
    doReset();
    @(negedge clk);
    chk("R11 acc cleared", accOut, 8'h00);
    chk("R11 page cleared", pageOut, 8'h00);
    chk("R11 flag cleared", flagOut, 1'b0);
    chk("R11 state kept", stateOut, 8'h20);
    chk("R11 ind kept", indOut, 8'h45);
  endtask

  task automatic t_clrBranch();
    putProg(8'h20, mk(4'h3, 2'b00, 1'b0, 8'h00, 8'h30, 8'h31));
    setReg(2'b00, 8'h55);
    runInstr();
    chk("R4 clr result", accOut, 8'h00);
    chk("R4 clr flag", flagOut, 1'b1);
    chk("R3 flag set picks high successor", stateOut, 8'h31);
  endtask

  task automatic t_ram();
    int w0;
    putProg(8'h31, mk(4'h0, 2'b01, 1'b0, 8'h10, 8'h40, 8'h41));
    putProg(8'h40, mk(4'hC, 2'b00, 1'b0, 8'h10, 8'h42, 8'h43));
    setReg(2'b00, 8'h3C);
    w0 = wrCount;
    runInstr();
    chk("R9 one write pulse", 16'(wrCount - w0), 16'd1);
    chk("R9 write address", lastWrAddr, 16'h0010);
    chk("R9 write data", lastWrData, 8'h3C);
    chk("R3 flag clear picks low successor", stateOut, 8'h40);
    setReg(2'b00, 8'hF0);
    runInstr();
    chk("R10 RAM readback add", accOut, 8'h2C);
    chk("R6 add carry", flagOut, 1'b1);
    chk("R3 carry successor", stateOut, 8'h43);
  endtask

  task automatic t_indirect();
    putProg(8'h43, mk(4'h1, 2'b00, 1'b1, 8'h99, 8'h50, 8'h51));
    setReg(2'b11, 8'h20);
    setReg(2'b10, 8'h44);
    runInstr();
    chk("R1 indirect read address", lastRdAddr, 16'h2044);
    chk("R1 indirect operand", accOut, 8'h1E);
    chk("R10 device operand successor", stateOut, 8'h50);
  endtask

  task automatic t_rotate();
    putProg(8'h50, mk(4'h8, 2'b00, 1'b0, 8'h00, 8'h52, 8'h53));
    putProg(8'h52, mk(4'h9, 2'b00, 1'b0, 8'h00, 8'h54, 8'h55));
    setReg(2'b00, 8'h81);
    runInstr();
    chk("R5 rotate left", accOut, 8'h03);
    chk("R5 rotate left flag", flagOut, 1'b0);
    runInstr();
    chk("R5 rotate right", accOut, 8'h81);
    chk("R5 rotate right flag", flagOut, 1'b1);
    chk("R5 rotate successor", stateOut, 8'h55);
  endtask

  task automatic t_arith();
    putProg(8'h55, mk(4'hE, 2'b00, 1'b0, 8'hA5, 8'h56, 8'h57));
    putProg(8'h57, mk(4'h2, 2'b00, 1'b0, 8'h0F, 8'h58, 8'h59));
    putProg(8'h59, mk(4'hF, 2'b00, 1'b0, 8'h00, 8'h5A, 8'h5B));
    runInstr();
    chk("R6 increment memory wraps", accOut, 8'h00);
    chk("R6 increment carry", flagOut, 1'b1);
    setReg(2'b00, 8'h55);
    runInstr();
    chk("R4 xor zero", accOut, 8'h00);
    chk("R4 xor zero flag", flagOut, 1'b1);
    setReg(2'b00, 8'h66);
    runInstr();
    chk("R4 unused opcode keeps acc", accOut, 8'h66);
    chk("R4 unused opcode clears flag", flagOut, 1'b0);
    chk("R4 unused opcode successor", stateOut, 8'h5A);
  endtask

  task automatic t_dest();
    int w0;
    putProg(8'h5A, mk(4'h1, 2'b11, 1'b0, 8'h33, 8'h60, 8'h61));
    putProg(8'h60, mk(4'h4, 2'b10, 1'b0, 8'h00, 8'h62, 8'h63));
    w0 = wrCount;
    runInstr();
    chk("R2 page destination", pageOut, 8'h69);
    runInstr();
    chk("R2 ind destination", indOut, 8'h99);
    chk("R2 acc untouched", accOut, 8'h66);
    chk("R9 no write for other destinations", 16'(wrCount - w0), 16'd0);
    chk("R2 successor", stateOut, 8'h62);
  endtask

  task automatic t_manual();
    int w0;
    putProg(8'h62, mk(4'h0, 2'b01, 1'b0, 8'h77, 8'h64, 8'h65));
    w0 = wrCount;
    @(posedge clk); #1 run = 1'b1; manual = 1'b1; step = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8 no step holds state", stateOut, 8'h62);
    chk("R8 no step no read", busRd, 1'b0);
    pulseStep();
    chk("R7 read phase strobe", busRd, 1'b1);
    pulseStep();
    chk("R7 read strobe drops", busRd, 1'b0);
    chk("R9 no write before step", 16'(wrCount - w0), 16'd0);
    repeat (2) @(negedge clk);
    chk("R9 held writeback no write", 16'(wrCount - w0), 16'd0);
    pulseStep();
    chk("R9 device write pulse", 16'(wrCount - w0), 16'd1);
    chk("R9 device write address", lastWrAddr, 16'h6977);
    chk("R9 device write data", lastWrData, 8'h66);
    chk("R8 step completes instruction", stateOut, 8'h64);
    #1 run = 1'b0; manual = 1'b0;
  endtask

  task automatic t_haltReset();
    putProg(8'h64, mk(4'hD, 2'b00, 1'b0, 8'h00, 8'h66, 8'h67));
    setReg(2'b00, 8'h10);
    @(posedge clk); #1 run = 1'b1;
    @(posedge clk); #1 run = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 halt keeps state", stateOut, 8'h64);
    chk("R8 halt keeps acc", accOut, 8'h10);
    @(posedge clk); #1 run = 1'b1;
    @(posedge clk); #1 run = 1'b0;
    doReset();
    @(negedge clk);
    chk("R11 mid-instruction reset acc", accOut, 8'h00);
    chk("R11 mid-instruction reset state", stateOut, 8'h64);
    runInstr();
    chk("R11 restart from fetch", accOut, 8'h01);
    chk("R6 increment no carry", flagOut, 1'b0);
    chk("R7 full instruction after restart", stateOut, 8'h66);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    rstN = 1'b0; run = 1'b0; manual = 1'b0; step = 1'b0;
    regWe = 1'b0; regSel = 2'b00; regData = 8'h00;
    progWe = 1'b0; progAddr = 8'h00; progData = 32'h0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_clrBranch();
    t_ram();
    t_indirect();
    t_rotate();
    t_arith();
    t_dest();
    t_manual();
    t_haltReset();
    finishRun();
  end

  initial begin
    #1000000;
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual running expected finished");
    finishRun();
  end
endmodule